// File: doc/BRIEF.md
# Fixed-Point Saturating Lane ALU

This block is the arithmetic core of one element lane in a vector unit. On every clock it accepts a pair of SEW-bit source operands, a 6-bit opcode, a 2-bit rounding mode and a flag saying whether the element is active. One clock later it presents the element result together with a flag that says whether a saturating operation had to clamp. Element sequencing, register-file access and register grouping are handled elsewhere. The lane sees one element at a time.

The lane covers plain wrapping arithmetic and logic, signed and unsigned minimum and maximum, and the three plain shifts. It also covers the fixed-point group: saturating add and subtract in signed and unsigned forms, scaling right shifts with rounding, and the signed fractional multiply. Saturating operations widen their operands by one bit, so overflow is seen exactly. Scaling shifts and the fractional multiply add a rounding increment chosen by the mode input before the result is cut to SEW bits. A masked-off element returns the previous destination value unchanged. The sticky overflow status kept outside can then be updated from the flag.

Top module: `fxl_lane_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` becomes zero and `sat_o` becomes 0 at that edge.
- R2: Results appear on the clock edge that samples the inputs. Wrapping ops (b = `src_b_i`, a = `src_a_i`): 0x00 b+a, 0x02 b-a, 0x09 b AND a, 0x0A b OR a, 0x0B b XOR a, all modulo 2^SEW.
- R3: Opcode 0x20 adds b and a as unsigned values. A sum that does not fit gives all-ones with `sat_o` = 1.
- R4: Opcodes 0x21 (b+a) and 0x23 (b-a) work on signed values. Results above the SEW-bit signed range give 0x7F..F and results below it give 0x80..0, each with `sat_o` = 1.
- R5: Opcode 0x22 gives unsigned b-a. If b < a it gives zero with `sat_o` = 1.
- R6: The following opcodes compare the full SEW bits: 0x04 unsigned minimum, 0x05 signed minimum, 0x06 unsigned maximum, 0x07 signed maximum.
- R7: The shift amount is the low log2(SEW) bits of a. The shifts are 0x25 b shifted left, 0x28 b shifted right logically, and 0x29 b shifted right arithmetically.
- R8: Opcodes 0x2A (logical) and 0x2B (arithmetic) shift b right by d and add an increment taken from the bits of b. The mode encodings are 0 = nearest-up, 1 = nearest-even, 2 = down and 3 = odd. Nearest-up adds bit d-1. Nearest-even adds bit d-1 AND (bit d OR any bit below d-1). Down adds 0. Odd adds 1 when bit d is 0 and any bit below d is 1. When d = 0 the increment is 0.
- R9: Opcode 0x27 forms the 2*SEW-bit signed product of b and a and shifts it right by SEW-1. It then adds the R8 increment for d = SEW-1 and saturates to SEW signed bits, setting `sat_o` when it clamps. The case most-negative times most-negative gives 0x7F..F.
- R10: When `active_i` = 0, `result_o` takes `old_dst_i` and `sat_o` is 0, whatever the opcode.
- R11: Any opcode not listed above gives a zero result with `sat_o` = 0.
- R12: `sat_o` is 1 only in the cycle after an active saturating opcode (0x20 to 0x23, 0x27) had to clamp. A result that fits exactly leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Operation code |
| rnd_mode_i | input | 2 | Fixed-point rounding mode |
| active_i | input | 1 | Element is active (1) or masked off (0) |
| src_b_i | input | SEW | First source operand (b) |
| src_a_i | input | SEW | Second source operand (a), also the shift amount |
| old_dst_i | input | SEW | Previous destination value for masked-off elements |
| result_o | output | SEW | Registered element result |
| sat_o | output | 1 | Registered saturation-clamp flag |

## Verification
The only state is the output register, so a wrong internal value shows on `result_o` or `sat_o` on the very next edge after the offending inputs. It never appears later. The vector table aims at the places where a faulty widening or rounding term would change the visible value. These are sums one step past each signed and unsigned limit, sums that land exactly on a limit, and shift patterns whose discarded bits separate the four rounding modes. They also include the zero-amount shift and the single overflowing fractional product. A mix-up between the signed and unsigned forms shows as a wrong minimum, maximum or clamp value in the same cycle.

// File: rtl/fxl_pkg.sv
package fxl_pkg;

    typedef enum logic [5:0] {
        OP_ADD   = 6'h00,
        OP_SUB   = 6'h02,
        OP_MINU  = 6'h04,
        OP_MIN   = 6'h05,
        OP_MAXU  = 6'h06,
        OP_MAX   = 6'h07,
        OP_AND   = 6'h09,
        OP_OR    = 6'h0A,
        OP_XOR   = 6'h0B,
        OP_SADDU = 6'h20,
        OP_SADD  = 6'h21,
        OP_SSUBU = 6'h22,
        OP_SSUB  = 6'h23,
        OP_SLL   = 6'h25,
        OP_SMUL  = 6'h27,
        OP_SRL   = 6'h28,
        OP_SRA   = 6'h29,
        OP_SSRL  = 6'h2A,
        OP_SSRA  = 6'h2B
    } op_e;

    typedef enum logic [1:0] {
        RND_NEAR_UP   = 2'd0,
        RND_NEAR_EVEN = 2'd1,
        RND_DOWN      = 2'd2,
        RND_ODD       = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_PLAIN,
        GRP_SAT,
        GRP_SHIFT
    } grp_e;

    typedef struct packed {
        logic active;
        op_e  op;
        rnd_e mode;
    } lane_ctl_t;

    function automatic grp_e op_group(logic [5:0] code);
        case (code)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
            OP_MINU, OP_MIN, OP_MAXU, OP_MAX:            return GRP_PLAIN;
            OP_SADDU, OP_SADD, OP_SSUBU, OP_SSUB, OP_SMUL: return GRP_SAT;
            OP_SLL, OP_SRL, OP_SRA, OP_SSRL, OP_SSRA:    return GRP_SHIFT;
            default:                                     return GRP_NONE;
        endcase
    endfunction

    function automatic logic is_sat_op(logic [5:0] code);
        return op_group(code) == GRP_SAT;
    endfunction

endpackage

// File: rtl/fxl_rounder.sv
module fxl_rounder
    import fxl_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  rnd_e          mode,
    output logic          incr
);
    logic [W-1:0] out_mask;
    logic [W-1:0] low_mask;
    logic         kept_lsb;
    logic         half_bit;
    logic         below_half;
    logic         any_out;

    always_comb begin
        out_mask   = (W'(1) << amt) - W'(1);
        low_mask   = out_mask >> 1;
        any_out    = |(val & out_mask);
        below_half = |(val & low_mask);
        kept_lsb   = val[amt];
        half_bit   = (amt != '0) ? val[amt - AW'(1)] : 1'b0;
        unique case (mode)
            RND_NEAR_UP:   incr = half_bit;
            RND_NEAR_EVEN: incr = half_bit & (kept_lsb | below_half);
            RND_DOWN:      incr = 1'b0;
            RND_ODD:       incr = ~kept_lsb & any_out;
            default:       incr = 1'b0;
        endcase
        if (amt == '0) begin
            incr = 1'b0;
        end
    end

    // R8: no rounding increment can arise when nothing is shifted out
    always_comb begin
        if (amt == '0) begin
            p_zero_shift_no_incr_r8: assert (!incr);
        end
    end

endmodule

// File: rtl/fxl_satarith.sv
module fxl_satarith
    import fxl_pkg::*;
#(
    parameter int SEW = 8
) (
    input  op_e            op,
    input  rnd_e           mode,
    input  logic [SEW-1:0] b,
    input  logic [SEW-1:0] a,
    output logic [SEW-1:0] res,
    output logic           sat
);
    localparam int PW  = 2 * SEW;
    localparam int PAW = $clog2(PW);
    localparam logic [PAW-1:0] MUL_SHIFT = PAW'(SEW - 1);
    localparam logic [SEW-1:0] MAX_POS   = {1'b0, {(SEW-1){1'b1}}};
    localparam logic [SEW-1:0] MIN_NEG   = {1'b1, {(SEW-1){1'b0}}};

    logic [SEW:0]          u_sum;
    logic [SEW:0]          s_sum;
    logic [SEW:0]          s_dif;
    logic signed [PW-1:0]  prod;
    logic                  mul_incr;
    logic [SEW:0]          mul_win;

    fxl_rounder #(.W(PW), .AW(PAW)) u_mul_round (
        .val  (prod),
        .amt  (MUL_SHIFT),
        .mode (mode),
        .incr (mul_incr)
    );

    always_comb begin
        u_sum   = {1'b0, b} + {1'b0, a};
        s_sum   = {b[SEW-1], b} + {a[SEW-1], a};
        s_dif   = {b[SEW-1], b} - {a[SEW-1], a};
        prod    = $signed(b) * $signed(a);
        mul_win = prod[PW-1:SEW-1] + {{SEW{1'b0}}, mul_incr};
        res     = '0;
        sat     = 1'b0;
        unique case (op)
            OP_SADDU: begin
                sat = u_sum[SEW];
                res = sat ? '1 : u_sum[SEW-1:0];
            end
            OP_SADD: begin
                sat = s_sum[SEW] ^ s_sum[SEW-1];
                res = sat ? (s_sum[SEW] ? MIN_NEG : MAX_POS) : s_sum[SEW-1:0];
            end
            OP_SSUBU: begin
                sat = b < a;
                res = sat ? '0 : (b - a);
            end
            OP_SSUB: begin
                sat = s_dif[SEW] ^ s_dif[SEW-1];
                res = sat ? (s_dif[SEW] ? MIN_NEG : MAX_POS) : s_dif[SEW-1:0];
            end
            OP_SMUL: begin
                sat = mul_win[SEW] ^ mul_win[SEW-1];
                res = sat ? (mul_win[SEW] ? MIN_NEG : MAX_POS) : mul_win[SEW-1:0];
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end

    // R4/R9: a signed clamp lands on one of the two signed limits
    always_comb begin
        if (sat && (op == OP_SADD || op == OP_SSUB || op == OP_SMUL)) begin
            p_signed_clamp_limit_r4: assert (res == MAX_POS || res == MIN_NEG);
        end
    end

endmodule

// File: rtl/fxl_shifter.sv
module fxl_shifter
    import fxl_pkg::*;
#(
    parameter int SEW = 8,
    parameter int AW  = $clog2(SEW)
) (
    input  op_e            op,
    input  rnd_e           mode,
    input  logic [SEW-1:0] b,
    input  logic [AW-1:0]  amt,
    output logic [SEW-1:0] res
);
    logic [2*SEW-1:0] b_ext;
    logic [SEW-1:0]   sh_left;
    logic [SEW-1:0]   sh_logic;
    logic [SEW-1:0]   sh_arith;
    logic             rnd_incr;

    fxl_rounder #(.W(SEW), .AW(AW)) u_shift_round (
        .val  (b),
        .amt  (amt),
        .mode (mode),
        .incr (rnd_incr)
    );

    always_comb begin
        b_ext    = {{SEW{b[SEW-1]}}, b};
        sh_left  = b << amt;
        sh_logic = b >> amt;
        sh_arith = SEW'(b_ext >> amt);
        unique case (op)
            OP_SLL:  res = sh_left;
            OP_SRL:  res = sh_logic;
            OP_SRA:  res = sh_arith;
            OP_SSRL: res = sh_logic + SEW'(rnd_incr);
            OP_SSRA: res = sh_arith + SEW'(rnd_incr);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/fxl_lane_alu.sv
module fxl_lane_alu
    import fxl_pkg::*;
#(
    parameter int SEW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [5:0]     op_i,
    input  logic [1:0]     rnd_mode_i,
    input  logic           active_i,
    input  logic [SEW-1:0] src_b_i,
    input  logic [SEW-1:0] src_a_i,
    input  logic [SEW-1:0] old_dst_i,
    output logic [SEW-1:0] result_o,
    output logic           sat_o
);
    localparam int AW = $clog2(SEW);

    lane_ctl_t      ctl;
    logic [SEW-1:0] plain_res;
    logic [SEW-1:0] sat_res;
    logic           sat_flag;
    logic [SEW-1:0] shift_res;
    logic [SEW-1:0] nxt_res;
    logic           nxt_sat;

    assign ctl.active = active_i;
    assign ctl.op     = op_e'(op_i);
    assign ctl.mode   = rnd_e'(rnd_mode_i);

    fxl_satarith #(.SEW(SEW)) u_sat (
        .op   (ctl.op),
        .mode (ctl.mode),
        .b    (src_b_i),
        .a    (src_a_i),
        .res  (sat_res),
        .sat  (sat_flag)
    );

    fxl_shifter #(.SEW(SEW), .AW(AW)) u_shift (
        .op   (ctl.op),
        .mode (ctl.mode),
        .b    (src_b_i),
        .amt  (src_a_i[AW-1:0]),
        .res  (shift_res)
    );

    always_comb begin
        unique case (ctl.op)
            OP_ADD:  plain_res = src_b_i + src_a_i;
            OP_SUB:  plain_res = src_b_i - src_a_i;
            OP_AND:  plain_res = src_b_i & src_a_i;
            OP_OR:   plain_res = src_b_i | src_a_i;
            OP_XOR:  plain_res = src_b_i ^ src_a_i;
            OP_MINU: plain_res = (src_b_i < src_a_i) ? src_b_i : src_a_i;
            OP_MAXU: plain_res = (src_b_i > src_a_i) ? src_b_i : src_a_i;
            OP_MIN:  plain_res = ($signed(src_b_i) < $signed(src_a_i)) ? src_b_i : src_a_i;
            OP_MAX:  plain_res = ($signed(src_b_i) > $signed(src_a_i)) ? src_b_i : src_a_i;
            default: plain_res = '0;
        endcase
    end

    always_comb begin
        nxt_res = '0;
        nxt_sat = 1'b0;
        unique case (op_group(op_i))
            GRP_PLAIN: nxt_res = plain_res;
            GRP_SAT: begin
                nxt_res = sat_res;
                nxt_sat = sat_flag;
            end
            GRP_SHIFT: nxt_res = shift_res;
            default:   nxt_res = '0;
        endcase
        if (!ctl.active) begin
            nxt_res = old_dst_i;
            nxt_sat = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            sat_o    <= 1'b0;
        end else begin
            result_o <= nxt_res;
            sat_o    <= nxt_sat;
        end
    end

    // R1: reset clears both outputs on the following edge
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !sat_o));

    // R10: a masked-off element reproduces the old destination
    p_inactive_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> (result_o == $past(old_dst_i) && !sat_o));

    // R12: only saturating opcodes can raise the flag
    p_sat_only_clamp_r12: assert property (@(posedge clk) disable iff (rst)
        (!is_sat_op(op_i)) |=> !sat_o);

    // R3: unsigned saturating add never wraps below either operand
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (active_i && op_i == OP_SADDU) |=>
            (result_o >= $past(src_b_i) && result_o >= $past(src_a_i)));

    // R5: unsigned saturating subtract floors at zero with the flag set
    p_sub_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (active_i && op_i == OP_SSUBU && src_b_i < src_a_i) |=>
            (result_o == '0 && sat_o));

    // R6: unsigned minimum is one of the operands and no larger than either
    p_minu_pick_r6: assert property (@(posedge clk) disable iff (rst)
        (active_i && op_i == OP_MINU) |=>
            (result_o <= $past(src_b_i) && result_o <= $past(src_a_i) &&
             (result_o == $past(src_b_i) || result_o == $past(src_a_i))));

endmodule

// File: tb/fxl_lane_alu_tb.sv
`timescale 1ns/1ps
module fxl_lane_alu_tb_top;

    localparam int SEW = 8;

    typedef struct packed {
        logic [5:0]     op;
        logic [1:0]     mode;
        logic           act;
        logic [SEW-1:0] b;
        logic [SEW-1:0] a;
        logic [SEW-1:0] old;
        logic [SEW-1:0] exp_res;
        logic           exp_sat;
        logic [3:0]     req;
    } vec_t;

    localparam int NV = 57;

    localparam vec_t VECS [NV] = '{
        // R2 wrapping group
        '{6'h00, 2'd0, 1'b1, 8'hF0, 8'h20, 8'h00, 8'h10, 1'b0, 4'd2},
        '{6'h02, 2'd0, 1'b1, 8'h05, 8'h07, 8'h00, 8'hFE, 1'b0, 4'd2},
        '{6'h09, 2'd0, 1'b1, 8'hCC, 8'hAA, 8'h00, 8'h88, 1'b0, 4'd2},
        '{6'h0A, 2'd0, 1'b1, 8'hCC, 8'hAA, 8'h00, 8'hEE, 1'b0, 4'd2},
        '{6'h0B, 2'd0, 1'b1, 8'hCC, 8'hAA, 8'h00, 8'h66, 1'b0, 4'd2},
        // R3 unsigned saturating add
        '{6'h20, 2'd0, 1'b1, 8'hF0, 8'h20, 8'h00, 8'hFF, 1'b1, 4'd3},
        '{6'h20, 2'd0, 1'b1, 8'h10, 8'h20, 8'h00, 8'h30, 1'b0, 4'd3},
        '{6'h20, 2'd0, 1'b1, 8'hFF, 8'h01, 8'h00, 8'hFF, 1'b1, 4'd3},
        // R4 signed saturating add / sub
        '{6'h21, 2'd0, 1'b1, 8'h70, 8'h20, 8'h00, 8'h7F, 1'b1, 4'd4},
        '{6'h21, 2'd0, 1'b1, 8'h90, 8'hE0, 8'h00, 8'h80, 1'b1, 4'd4},
        '{6'h21, 2'd0, 1'b1, 8'h10, 8'hF0, 8'h00, 8'h00, 1'b0, 4'd4},
        '{6'h23, 2'd0, 1'b1, 8'h80, 8'h01, 8'h00, 8'h80, 1'b1, 4'd4},
        '{6'h23, 2'd0, 1'b1, 8'h7F, 8'hFF, 8'h00, 8'h7F, 1'b1, 4'd4},
        '{6'h23, 2'd0, 1'b1, 8'h05, 8'h03, 8'h00, 8'h02, 1'b0, 4'd4},
        // R5 unsigned saturating subtract
        '{6'h22, 2'd0, 1'b1, 8'h03, 8'h05, 8'h00, 8'h00, 1'b1, 4'd5},
        '{6'h22, 2'd0, 1'b1, 8'h05, 8'h03, 8'h00, 8'h02, 1'b0, 4'd5},
        '{6'h22, 2'd0, 1'b1, 8'h40, 8'h40, 8'h00, 8'h00, 1'b0, 4'd5},
        // R6 min / max
        '{6'h04, 2'd0, 1'b1, 8'h80, 8'h01, 8'h00, 8'h01, 1'b0, 4'd6},
        '{6'h05, 2'd0, 1'b1, 8'h80, 8'h01, 8'h00, 8'h80, 1'b0, 4'd6},
        '{6'h06, 2'd0, 1'b1, 8'h80, 8'h01, 8'h00, 8'h80, 1'b0, 4'd6},
        '{6'h07, 2'd0, 1'b1, 8'h80, 8'h01, 8'h00, 8'h01, 1'b0, 4'd6},
        '{6'h05, 2'd0, 1'b1, 8'hFE, 8'hFD, 8'h00, 8'hFD, 1'b0, 4'd6},
        '{6'h07, 2'd0, 1'b1, 8'hFE, 8'hFD, 8'h00, 8'hFE, 1'b0, 4'd6},
        // R7 plain shifts, amount from low 3 bits
        '{6'h25, 2'd0, 1'b1, 8'h81, 8'h09, 8'h00, 8'h02, 1'b0, 4'd7},
        '{6'h28, 2'd0, 1'b1, 8'h80, 8'h0F, 8'h00, 8'h01, 1'b0, 4'd7},
        '{6'h29, 2'd0, 1'b1, 8'h80, 8'h02, 8'h00, 8'hE0, 1'b0, 4'd7},
        '{6'h29, 2'd0, 1'b1, 8'h40, 8'h02, 8'h00, 8'h10, 1'b0, 4'd7},
        // R8 scaling shifts, all four modes
        '{6'h2A, 2'd0, 1'b1, 8'h0B, 8'h02, 8'h00, 8'h03, 1'b0, 4'd8},
        '{6'h2A, 2'd1, 1'b1, 8'h0B, 8'h02, 8'h00, 8'h03, 1'b0, 4'd8},
        '{6'h2A, 2'd2, 1'b1, 8'h0B, 8'h02, 8'h00, 8'h02, 1'b0, 4'd8},
        '{6'h2A, 2'd3, 1'b1, 8'h0B, 8'h02, 8'h00, 8'h03, 1'b0, 4'd8},
        '{6'h2A, 2'd0, 1'b1, 8'h0A, 8'h02, 8'h00, 8'h03, 1'b0, 4'd8},
        '{6'h2A, 2'd1, 1'b1, 8'h0A, 8'h02, 8'h00, 8'h02, 1'b0, 4'd8},
        '{6'h2A, 2'd2, 1'b1, 8'h0A, 8'h02, 8'h00, 8'h02, 1'b0, 4'd8},
        '{6'h2A, 2'd3, 1'b1, 8'h0A, 8'h02, 8'h00, 8'h03, 1'b0, 4'd8},
        '{6'h2A, 2'd1, 1'b1, 8'h0E, 8'h02, 8'h00, 8'h04, 1'b0, 4'd8},
        '{6'h2A, 2'd3, 1'b1, 8'h0E, 8'h02, 8'h00, 8'h03, 1'b0, 4'd8},
        '{6'h2A, 2'd0, 1'b1, 8'h0B, 8'h08, 8'h00, 8'h0B, 1'b0, 4'd8},
        '{6'h2A, 2'd3, 1'b1, 8'h0B, 8'h08, 8'h00, 8'h0B, 1'b0, 4'd8},
        '{6'h2B, 2'd0, 1'b1, 8'hF6, 8'h02, 8'h00, 8'hFE, 1'b0, 4'd8},
        '{6'h2B, 2'd1, 1'b1, 8'hF6, 8'h02, 8'h00, 8'hFE, 1'b0, 4'd8},
        '{6'h2B, 2'd2, 1'b1, 8'hF6, 8'h02, 8'h00, 8'hFD, 1'b0, 4'd8},
        '{6'h2B, 2'd3, 1'b1, 8'hF5, 8'h02, 8'h00, 8'hFD, 1'b0, 4'd8},
        // R9 fractional multiply
        '{6'h27, 2'd0, 1'b1, 8'h80, 8'h80, 8'h00, 8'h7F, 1'b1, 4'd9},
        '{6'h27, 2'd0, 1'b1, 8'h40, 8'h40, 8'h00, 8'h20, 1'b0, 4'd9},
        '{6'h27, 2'd0, 1'b1, 8'h0C, 8'h08, 8'h00, 8'h01, 1'b0, 4'd9},
        '{6'h27, 2'd1, 1'b1, 8'h0C, 8'h08, 8'h00, 8'h01, 1'b0, 4'd9},
        '{6'h27, 2'd2, 1'b1, 8'h0C, 8'h08, 8'h00, 8'h00, 1'b0, 4'd9},
        '{6'h27, 2'd1, 1'b1, 8'h08, 8'h08, 8'h00, 8'h00, 1'b0, 4'd9},
        '{6'h27, 2'd3, 1'b1, 8'h08, 8'h08, 8'h00, 8'h01, 1'b0, 4'd9},
        '{6'h27, 2'd0, 1'b1, 8'h80, 8'h40, 8'h00, 8'hC0, 1'b0, 4'd9},
        // R10 masked-off element
        '{6'h20, 2'd0, 1'b0, 8'hF0, 8'h20, 8'h5A, 8'h5A, 1'b0, 4'd10},
        '{6'h00, 2'd0, 1'b0, 8'h11, 8'h22, 8'hA5, 8'hA5, 1'b0, 4'd10},
        // R11 unlisted opcodes
        '{6'h3F, 2'd0, 1'b1, 8'h12, 8'h34, 8'h33, 8'h00, 1'b0, 4'd11},
        '{6'h01, 2'd0, 1'b1, 8'h12, 8'h34, 8'h33, 8'h00, 1'b0, 4'd11},
        // R12 exact fit leaves the flag low
        '{6'h20, 2'd0, 1'b1, 8'h7F, 8'h80, 8'h00, 8'hFF, 1'b0, 4'd12},
        '{6'h21, 2'd0, 1'b1, 8'h7F, 8'h00, 8'h00, 8'h7F, 1'b0, 4'd12}
    };

    logic           clk = 1'b0;
    logic           rst;
    logic [5:0]     op_i;
    logic [1:0]     rnd_mode_i;
    logic           active_i;
    logic [SEW-1:0] src_b_i;
    logic [SEW-1:0] src_a_i;
    logic [SEW-1:0] old_dst_i;
    logic [SEW-1:0] result_o;
    logic           sat_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fxl_lane_alu #(.SEW(SEW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op_i),
        .rnd_mode_i (rnd_mode_i),
        .active_i   (active_i),
        .src_b_i    (src_b_i),
        .src_a_i    (src_a_i),
        .old_dst_i  (old_dst_i),
        .result_o   (result_o),
        .sat_o      (sat_o)
    );

    task automatic check(input int req, input int idx,
                         input logic [SEW-1:0] exp_res, input logic exp_sat);
        checks++;
        if (result_o !== exp_res || sat_o !== exp_sat) begin
            errors++;
            $display("FAIL R%0d case %0d: result %02h sat %0b, expected %02h sat %0b",
                     req, idx, result_o, sat_o, exp_res, exp_sat);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i       = v.op;
        rnd_mode_i = v.mode;
        active_i   = v.act;
        src_b_i    = v.b;
        src_a_i    = v.a;
        old_dst_i  = v.old;
    endtask

    initial begin
        rst = 1'b1;
        drive('{6'h20, 2'd0, 1'b1, 8'hF0, 8'h20, 8'h00, 8'h00, 1'b0, 4'd0});
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(1, -1, 8'h00, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(int'(VECS[i].req), i, VECS[i].exp_res, VECS[i].exp_sat);
        end

        // R1: reset after a clamping result clears both outputs
        drive('{6'h20, 2'd0, 1'b1, 8'hF0, 8'h20, 8'h00, 8'h00, 1'b0, 4'd0});
        @(negedge clk);
        check(3, 100, 8'hFF, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check(1, 101, 8'h00, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check(3, 102, 8'hFF, 1'b1);

        // R2: output holds the previous result until the next edge
        drive('{6'h00, 2'd0, 1'b1, 8'h01, 8'h01, 8'h00, 8'h00, 1'b0, 4'd0});
        #1;
        check(2, 103, 8'hFF, 1'b1);
        @(negedge clk);
        check(2, 104, 8'h02, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule